// File: doc/BRIEF.md
# Six-Channel Shadowed PWM Controller

This block generates six independent pulse-width-modulated outputs from one reference clock. Software programs each channel through a small window of memory-mapped words. The words cover a control word, a repeat count, a period length, a first-phase length and a read-only status word. All lengths count reference clock cycles. Period and first-phase lengths are written into holding copies. They reach the waveform only when software writes the commit bit, and both values move to the live counter together, so a period never mixes an old and a new setting.

A channel either runs without end or, in one-shot mode, waits for a chosen edge on its event input. It then plays a set number of periods, stops and raises a done flag that can drive an interrupt line. A polarity bit picks the level of the first phase. A second bit picks the level the pin holds whenever the channel is not producing a waveform. A self-clearing reset bit returns a single channel to a blank state without touching its neighbours.

Top module: `pwmc_top`

## Requirements
- R1: Channel n occupies bytes n*0x20 to n*0x20+0x1F. Offsets within a window: 0x00 control, 0x04 repeat, 0x08 period, 0x0C first-phase length, 0x10 status. Repeat, period and first-phase length read back the last value written to that channel only. A read from any address with no channel decodes as 0.
- R2: Control bits are: 0 run, 1 channel reset, 2 commit, 3 interrupt enable, 4 one-shot, 5 continuous, 6 trigger on rising event, 7 trigger on falling event, 8 first-phase level, 9 idle level. Bits 1 and 2 act only when written and always read back as 0.
- R3: In continuous mode with period P>0 and first-phase length D<P, the output repeats a pattern of P cycles: D cycles at the first-phase level, then P-D cycles at the opposite level. The first cycle after the write that sets the run bit is cycle 0 of a period.
- R4: With bit 8 set the first phase is high. With bit 8 clear it is low and the second phase is high.
- R5: While the run bit is clear, the output equals control bit 9.
- R6: Writing the period or first-phase length words alone changes nothing at the output.
- R7: A commit issued while a waveform is playing takes effect at the start of the next period. The period in progress finishes with the old values, and both new values start together.
- R8: A commit issued while the channel produces no waveform loads the new values at once, so the next start uses them.
- R9: A first-phase length of 0 gives a constant second-phase level. A length equal to or above the period gives a constant first-phase level. A period of 0 holds the output at the idle level.
- R10: One-shot mode is selected by bit 4 set with bit 5 clear, otherwise the channel is continuous. In one-shot mode the channel stays at the idle level until an event edge armed by bit 6 (rising) or bit 7 (falling) arrives. It then plays max(repeat,1) periods, returns to idle and sets status bit 0 (done). Status bit 1 is high while a waveform plays. Unarmed edges do nothing.
- R11: The channel's interrupt output is high exactly when its done flag is set and bit 3 is set.
- R12: Writing control with bit 1 set clears that channel's repeat, period and first-phase words, its live values, its counters and its status. The other control bits are stored as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe, one word per cycle |
| addr | input | ADDR_W (8) | Byte address for writes and reads |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data for `addr`, combinational |
| evtIn | input | NUM_CH (6) | Per-channel trigger event, synchronous to clk |
| pwmOut | output | NUM_CH (6) | Per-channel PWM output |
| irq | output | NUM_CH (6) | Per-channel interrupt request |

## Verification
The bench aims at the commit timing. It rewrites the period and length in the middle of a running period, then commits one cycle later. A design that applies the values at the commit, or that takes them from the holding words at the boundary, bends the current period or shows a mixed period. The degenerate lengths (zero length, length equal to the period, zero period) are each driven with levels chosen so that a wrong branch gives the other level. One-shot runs cover a repeat of 2, a repeat of 0 that must still play once, and an unarmed edge that must be ignored. A channel reset follows and must wipe the holding words and the done flag while keeping the control word.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;

  localparam int WIN_BITS = 5;

  localparam logic [WIN_BITS-1:0] OFS_CTRL = 5'h00;
  localparam logic [WIN_BITS-1:0] OFS_REP  = 5'h04;
  localparam logic [WIN_BITS-1:0] OFS_PER  = 5'h08;
  localparam logic [WIN_BITS-1:0] OFS_DUTY = 5'h0C;
  localparam logic [WIN_BITS-1:0] OFS_STAT = 5'h10;

  localparam int B_START  = 0;
  localparam int B_SRST   = 1;
  localparam int B_COMMIT = 2;
  localparam int B_IRQEN  = 3;
  localparam int B_ONE    = 4;
  localparam int B_CONT   = 5;
  localparam int B_RISE   = 6;
  localparam int B_FALL   = 7;
  localparam int B_FPHI   = 8;
  localparam int B_IDLEHI = 9;
  localparam int CTRL_W   = 10;

  typedef struct packed {
    logic idleHigh;
    logic firstHigh;
    logic trigFall;
    logic trigRise;
    logic cont;
    logic oneShot;
    logic intEn;
    logic start;
  } chCfg_t;

  typedef struct packed {
    logic commit;
    logic softRst;
  } chStrobe_t;

  function automatic logic [CTRL_W-1:0] cfgWord(chCfg_t c);
    logic [CTRL_W-1:0] w;
    w           = '0;
    w[B_START]  = c.start;
    w[B_IRQEN]  = c.intEn;
    w[B_ONE]    = c.oneShot;
    w[B_CONT]   = c.cont;
    w[B_RISE]   = c.trigRise;
    w[B_FALL]   = c.trigFall;
    w[B_FPHI]   = c.firstHigh;
    w[B_IDLEHI] = c.idleHigh;
    return w;
  endfunction

endpackage

// File: rtl/pwmc_regs.sv
module pwmc_regs
  import pwmc_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            wrEn,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DATA_W-1:0]               wdata,
  output logic [DATA_W-1:0]               rdata,
  input  logic [NUM_CH-1:0][1:0]          status,
  output chCfg_t [NUM_CH-1:0]             cfg,
  output chStrobe_t [NUM_CH-1:0]          stb,
  output logic [NUM_CH-1:0][CNT_W-1:0]    shPer,
  output logic [NUM_CH-1:0][CNT_W-1:0]    shDuty,
  output logic [NUM_CH-1:0][CNT_W-1:0]    shRep
);

  localparam int SEL_W = ADDR_W - WIN_BITS;

  logic [SEL_W-1:0]    chSel;
  logic [WIN_BITS-1:0] ofs;
  logic                unusedBits;

  assign chSel      = addr[ADDR_W-1:WIN_BITS];
  assign ofs        = addr[WIN_BITS-1:0];
  assign unusedBits = ^wdata[DATA_W-1:CNT_W];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic              hit;
    chCfg_t            cfgR;
    logic [CNT_W-1:0]  perR, dutyR, repR;

    assign hit = wrEn && (chSel == SEL_W'(i));
    assign stb[i].softRst = hit && (ofs == OFS_CTRL) && wdata[B_SRST];
    assign stb[i].commit  = hit && (ofs == OFS_CTRL) && wdata[B_COMMIT];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgR  <= '0;
        perR  <= '0;
        dutyR <= '0;
        repR  <= '0;
      end else begin
        if (hit && ofs == OFS_CTRL) begin
          cfgR.start     <= wdata[B_START];
          cfgR.intEn     <= wdata[B_IRQEN];
          cfgR.oneShot   <= wdata[B_ONE];
          cfgR.cont      <= wdata[B_CONT];
          cfgR.trigRise  <= wdata[B_RISE];
          cfgR.trigFall  <= wdata[B_FALL];
          cfgR.firstHigh <= wdata[B_FPHI];
          cfgR.idleHigh  <= wdata[B_IDLEHI];
        end
        if (stb[i].softRst) begin
          perR  <= '0;
          dutyR <= '0;
          repR  <= '0;
        end else if (hit) begin
          case (ofs)
            OFS_REP:  repR  <= wdata[CNT_W-1:0];
            OFS_PER:  perR  <= wdata[CNT_W-1:0];
            OFS_DUTY: dutyR <= wdata[CNT_W-1:0];
            default: ;
          endcase
        end
      end
    end

    assign cfg[i]    = cfgR;
    assign shPer[i]  = perR;
    assign shDuty[i] = dutyR;
    assign shRep[i]  = repR;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (chSel == SEL_W'(i)) begin
        case (ofs)
          OFS_CTRL: rdata = DATA_W'(cfgWord(cfg[i]));
          OFS_REP:  rdata = DATA_W'(shRep[i]);
          OFS_PER:  rdata = DATA_W'(shPer[i]);
          OFS_DUTY: rdata = DATA_W'(shDuty[i]);
          OFS_STAT: rdata = DATA_W'(status[i]);
          default:  rdata = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/pwmc_chan.sv
module pwmc_chan
  import pwmc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  chCfg_t           cfg,
  input  chStrobe_t        stb,
  input  logic [CNT_W-1:0] shPer,
  input  logic [CNT_W-1:0] shDuty,
  input  logic [CNT_W-1:0] shRep,
  input  logic             evtIn,
  output logic             pwmOut,
  output logic             irq,
  output logic [1:0]       status
);

  logic             oneShotSel, emitting, boundary, trig;
  logic             evtPrev, running, done, pending;
  logic [CNT_W-1:0] cnt, actPer, actDuty, pendPer, pendDuty, repLeft;

  assign oneShotSel = cfg.oneShot && !cfg.cont;
  assign emitting   = cfg.start && (!oneShotSel || running);
  assign boundary   = (actPer == '0) || (cnt == actPer - 1'b1);
  assign trig       = oneShotSel && cfg.start && !running &&
                      ((cfg.trigRise && evtIn && !evtPrev) ||
                       (cfg.trigFall && !evtIn && evtPrev));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtPrev  <= 1'b0;
      running  <= 1'b0;
      done     <= 1'b0;
      pending  <= 1'b0;
      cnt      <= '0;
      actPer   <= '0;
      actDuty  <= '0;
      pendPer  <= '0;
      pendDuty <= '0;
      repLeft  <= '0;
    end else if (stb.softRst) begin
      evtPrev  <= evtIn;
      running  <= 1'b0;
      done     <= 1'b0;
      pending  <= 1'b0;
      cnt      <= '0;
      actPer   <= '0;
      actDuty  <= '0;
      pendPer  <= '0;
      pendDuty <= '0;
      repLeft  <= '0;
    end else begin
      evtPrev <= evtIn;

      if (!emitting || boundary) cnt <= '0;
      else                       cnt <= cnt + 1'b1;

      if (!cfg.start || !oneShotSel) begin
        running <= 1'b0;
      end else if (trig) begin
        running <= 1'b1;
        done    <= 1'b0;
        repLeft <= (shRep == '0) ? '0 : shRep - 1'b1;
      end else if (running && boundary) begin
        if (repLeft == '0) begin
          running <= 1'b0;
          done    <= 1'b1;
        end else begin
          repLeft <= repLeft - 1'b1;
        end
      end

      if (pending && (!emitting || boundary)) begin
        actPer  <= pendPer;
        actDuty <= pendDuty;
        pending <= 1'b0;
      end
      if (stb.commit) begin
        if (!emitting) begin
          actPer  <= shPer;
          actDuty <= shDuty;
          pending <= 1'b0;
        end else begin
          pendPer  <= shPer;
          pendDuty <= shDuty;
          pending  <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (emitting && actPer != '0)
      pwmOut = (cnt < actDuty) ? cfg.firstHigh : !cfg.firstHigh;
    else
      pwmOut = cfg.idleHigh;
  end

  assign irq    = done && cfg.intEn;
  assign status = {emitting, done};

endmodule

// File: rtl/pwmc_top.sv
module pwmc_top
  import pwmc_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NUM_CH-1:0] evtIn,
  output logic [NUM_CH-1:0] pwmOut,
  output logic [NUM_CH-1:0] irq
);

  chCfg_t    [NUM_CH-1:0]            cfgW;
  chStrobe_t [NUM_CH-1:0]            stbW;
  logic      [NUM_CH-1:0][CNT_W-1:0] perW, dutyW, repW;
  logic      [NUM_CH-1:0][1:0]       statW;

  pwmc_regs #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) uRegs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .status(statW), .cfg(cfgW), .stb(stbW),
    .shPer(perW), .shDuty(dutyW), .shRep(repW)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    pwmc_chan #(.CNT_W(CNT_W)) uChan (
      .clk(clk), .rstN(rstN), .cfg(cfgW[i]), .stb(stbW[i]),
      .shPer(perW[i]), .shDuty(dutyW[i]), .shRep(repW[i]),
      .evtIn(evtIn[i]), .pwmOut(pwmOut[i]), .irq(irq[i]),
      .status(statW[i])
    );
  end

endmodule

// File: rtl/pwmc_chk.sv
module pwmc_chk
  import pwmc_pkg::*;
#(
  parameter int NUM_CH = 6
) (
  input logic                   clk,
  input logic                   rstN,
  input chCfg_t    [NUM_CH-1:0] cfg,
  input chStrobe_t [NUM_CH-1:0] stb,
  input logic [NUM_CH-1:0][1:0] status,
  input logic [NUM_CH-1:0]      pwmOut,
  input logic [NUM_CH-1:0]      irq
);

  logic unusedChk;
  assign unusedChk = ^{cfg, stb};

  for (genvar i = 0; i < NUM_CH; i++) begin : g_prop
    // R5: a stopped channel shows its idle level
    a_r5_stop_idle: assert property (@(posedge clk) disable iff (!rstN)
      !cfg[i].start |-> pwmOut[i] == cfg[i].idleHigh);

    // R12: channel reset clears the done flag
    a_r12_srst_clears: assert property (@(posedge clk) disable iff (!rstN)
      stb[i].softRst |=> !status[i][0]);

    // R10: done only rises at the end of a played waveform
    a_r10_done_after_emit: assert property (@(posedge clk) disable iff (!rstN)
      $rose(status[i][0]) |-> $past(status[i][1]));

    // R10: a waveform plays only with the run bit set
    a_r10_emit_needs_start: assert property (@(posedge clk) disable iff (!rstN)
      status[i][1] |-> cfg[i].start);

    // R11: an interrupt appears only with done set
    a_r11_irq_needs_done: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irq[i]) |-> status[i][0]);
  end

endmodule

bind pwmc_top pwmc_chk #(.NUM_CH(NUM_CH)) uChk (
  .clk(clk), .rstN(rstN), .cfg(cfgW), .stb(stbW),
  .status(statW), .pwmOut(pwmOut), .irq(irq)
);

// File: tb/tb_pwmc_top.sv
module tb_pwmc_top;

  localparam int NUM_CH = 6;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam int C_START = 1,   C_SRST = 2,    C_COMMIT = 4,  C_IRQEN = 8;
  localparam int C_ONE   = 16,  C_CONT = 32,   C_RISE   = 64, C_FALL  = 128;
  localparam int C_FPHI  = 256, C_IDLEHI = 512;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic [NUM_CH-1:0] evtIn = '0;
  logic [NUM_CH-1:0] pwmOut;
  logic [NUM_CH-1:0] irq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    int    ch;
    logic  lvl;
    string tag;
  } waveItem_t;
  waveItem_t sb[$];

  always #5 clk = ~clk;

  pwmc_top #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .evtIn(evtIn), .pwmOut(pwmOut), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: one expected output level per cycle
  initial begin
    forever begin
      waveItem_t it;
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        check(it.tag, 32'(pwmOut[it.ch]), 32'(it.lvl));
      end
    end
  end

  task automatic push(int ch, logic lvl, int n, string tag);
    for (int k = 0; k < n; k++) sb.push_back('{ch, lvl, tag});
  endtask

  task automatic pushPat(int ch, int per, int duty, logic fp, int periods, string tag);
    for (int p = 0; p < periods; p++)
      for (int c = 0; c < per; c++)
        push(ch, (c < duty) ? fp : !fp, 1, tag);
  endtask

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    wrEn  = 1'b1;
    addr  = ADDR_W'(a);
    wdata = DATA_W'(d);
    @(negedge clk);
    wrEn  = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    addr = ADDR_W'(a);
    #1;
    d = rdata;
    @(negedge clk);
  endtask

  task automatic runCfg(int ch, int per, int duty, int ctrl);
    int b = ch * 32;
    wr(b, ctrl & ~C_START);
    wr(b + 8, per);
    wr(b + 12, duty);
    wr(b, (ctrl & ~C_START) | C_COMMIT);
    wr(b, ctrl);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    check("R5 reset outputs idle", 32'(pwmOut), 0);
    check("R11 reset irq", 32'(irq), 0);
    rd(32'h08, v); check("R1 reset period", v, 0);

    // R6, R8, R3, R2
    wr(32'h08, 5);
    wr(32'h0C, 2);
    wr(32'h00, C_FPHI | C_IDLEHI | C_CONT);
    wr(32'h00, C_FPHI | C_IDLEHI | C_CONT | C_START);
    push(0, 1'b1, 3, "R6 no commit keeps idle");
    drain();
    wr(32'h00, C_FPHI | C_IDLEHI | C_CONT);
    push(0, 1'b1, 1, "R5 stopped");
    drain();
    wr(32'h00, C_FPHI | C_IDLEHI | C_CONT | C_COMMIT);
    rd(32'h00, v); check("R2 commit bit reads 0", v, 32'h320);
    wr(32'h00, C_FPHI | C_IDLEHI | C_CONT | C_START);
    pushPat(0, 5, 2, 1'b1, 3, "R3 R8 waveform");
    drain();

    // R7: commit mid-period waits for boundary
    runCfg(0, 5, 2, C_FPHI | C_IDLEHI | C_CONT | C_START);
    pushPat(0, 5, 2, 1'b1, 1, "R7 old period completes");
    push(0, 1'b1, 6, "R7 R9 new values together");
    wr(32'h08, 3);
    wr(32'h0C, 3);
    wr(32'h00, C_FPHI | C_IDLEHI | C_CONT | C_START | C_COMMIT);
    drain();

    // R9 degenerate lengths
    runCfg(0, 3, 0, C_FPHI | C_IDLEHI | C_CONT | C_START);
    push(0, 1'b0, 6, "R9 zero length");
    drain();
    runCfg(0, 0, 2, C_FPHI | C_CONT | C_START);
    push(0, 1'b0, 6, "R9 zero period");
    drain();

    // R4 inverted polarity, R5 both idle levels
    runCfg(0, 4, 1, C_IDLEHI | C_CONT | C_START);
    pushPat(0, 4, 1, 1'b0, 3, "R4 inverted");
    drain();
    wr(32'h00, C_IDLEHI | C_CONT);
    push(0, 1'b1, 2, "R5 idle high");
    drain();
    wr(32'h00, C_CONT);
    push(0, 1'b0, 2, "R5 idle low");
    drain();

    // R1 decode
    wr(32'hA8, 32'h1234);
    rd(32'hA8, v); check("R1 ch5 period", v, 32'h1234);
    rd(32'h08, v); check("R1 ch0 period kept", v, 4);
    rd(32'hC8, v); check("R1 unmapped reads 0", v, 0);

    // R10 one-shot rising, repeat 2; R11 irq
    wr(32'h24, 2);
    runCfg(1, 3, 1, C_START | C_ONE | C_RISE | C_FPHI | C_IRQEN);
    push(1, 1'b0, 3, "R10 waiting");
    drain();
    rd(32'h30, v); check("R10 status waiting", v, 0);
    evtIn[1] = 1'b1;
    push(1, 1'b0, 1, "R10 trigger cycle");
    pushPat(1, 3, 1, 1'b1, 2, "R10 burst");
    push(1, 1'b0, 3, "R10 idle after burst");
    drain();
    rd(32'h30, v); check("R10 done flag", v, 1);
    check("R11 irq with enable", 32'(irq[1]), 1);
    evtIn[1] = 1'b0;
    push(1, 1'b0, 4, "R10 falling edge unarmed");
    drain();
    rd(32'h30, v); check("R10 done kept", v, 1);

    // R12 channel reset
    wr(32'h20, C_START | C_ONE | C_RISE | C_FPHI | C_IRQEN | C_SRST);
    rd(32'h30, v); check("R12 status cleared", v, 0);
    check("R12 irq cleared", 32'(irq[1]), 0);
    rd(32'h28, v); check("R12 period cleared", v, 0);
    rd(32'h24, v); check("R12 repeat cleared", v, 0);
    rd(32'h20, v); check("R12 R2 control kept", v, 32'h159);

    // R10 one-shot falling, repeat 0 plays once; R11 without enable
    runCfg(2, 2, 1, C_START | C_ONE | C_FALL | C_FPHI);
    evtIn[2] = 1'b1;
    push(2, 1'b0, 3, "R10 rising edge unarmed");
    drain();
    evtIn[2] = 1'b0;
    push(2, 1'b0, 1, "R10 falling trigger cycle");
    pushPat(2, 2, 1, 1'b1, 1, "R10 repeat 0 plays once");
    push(2, 1'b0, 3, "R10 idle after single");
    drain();
    rd(32'h50, v); check("R10 done ch2", v, 1);
    check("R11 irq masked", 32'(irq[2]), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule